// File: doc/BRIEF.md
# Enable-Triggered Saturating Down-Timer

This block holds an unsigned count that moves only on cycles where a periodic sample strobe is high. A rising edge of the run input, seen on the strobe, loads a programmed start value. While run stays high, each strobe takes a programmed step off the count, and the count stops at zero instead of wrapping. Dropping run forces the count to zero at the next strobe. A separate load request, also sampled on strobes, reloads the start value no matter what run is doing.

With a step of 1 the block counts discrete events. With the step set to the strobe period in some fixed-point unit, the count reads as remaining time in that unit. The busy output is high whenever the count is nonzero, which makes it usable as a one-shot window that restarts on each run rising edge.

Top module: `dtmr_timer`

## Requirements
- R1: A synchronous active-high `rst` clears `count`, `busy` and the stored run level. When `run` is already high at the first strobe after reset, that strobe loads `start_val`.
- R2: `count` and `busy` change only at a clock edge where `tick` is 1. They hold their values on every other cycle.
- R3: On a strobe where `run` is 1 and `run` was 0 at the previous strobe (or no strobe has occurred since reset), `count` becomes `start_val`.
- R4: On a strobe with `load_req` = 1, `count` becomes `start_val` whatever the value of `run`. A load takes priority over clear and step.
- R5: On a strobe with no load and `run` = 0, `count` becomes 0.
- R6: On a strobe with no load, `run` = 1 and `count` >= `step`, `count` becomes `count - step`.
- R7: On a strobe with no load, `run` = 1 and `count` < `step`, `count` becomes 0 and never wraps. This includes `count` = 0.
- R8: `busy` is 1 exactly when `count` is nonzero.
- R9: `start_val` and `step` matter only on the strobe that loads or steps. Changing them at other times leaves `count` unchanged.
- R10: `run` is sampled for edge detection only on strobes. A low pulse on `run` between two strobes does not cause a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe; all updates happen on it |
| run | input | 1 | Run level; its rising edge loads, its low level clears |
| load_req | input | 1 | Extra load request, combined with the edge pulse by OR |
| start_val | input | WIDTH | Unsigned value loaded on a load |
| step | input | WIDTH | Unsigned decrement per strobe |
| count | output | WIDTH | Current count |
| busy | output | 1 | High while count is nonzero |

## Verification
A stale stored run level appears at the first strobe after `run` rises. The count then keeps decrementing from its old value instead of jumping to `start_val`, or it reloads when no edge occurred. A faulty saturation or subtract path shows up on the one strobe where the count crosses below the step: the output wraps to a large value instead of reading zero. A `busy` flag that disagrees with the count shows on the same cycle the count is updated. All of these faults are visible one clock after the strobe that exposes them.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_STEP  = 2'd3
  } dtmr_action_e;

  // Priority: no strobe holds, then load, then clear on run low, else step.
  function automatic dtmr_action_e pick_action(input logic tick,
                                               input logic load,
                                               input logic run);
    if (!tick)      return ACT_HOLD;
    else if (load)  return ACT_LOAD;
    else if (!run)  return ACT_CLEAR;
    else            return ACT_STEP;
  endfunction

endpackage

// File: rtl/dtmr_edge_detect.sv
module dtmr_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic level,
  output logic rise
);

  logic level_prev;

  // Level is remembered only on strobes, so edges are seen per strobe.
  always_ff @(posedge clk) begin
    if (rst)       level_prev <= 1'b0;
    else if (tick) level_prev <= level;
  end

  assign rise = tick & level & ~level_prev;

endmodule

// File: rtl/dtmr_value_reg.sv
module dtmr_value_reg
  import dtmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dtmr_action_e     action,
  input  logic [WIDTH-1:0] start_val,
  input  logic [WIDTH-1:0] step,
  output logic [WIDTH-1:0] value,
  output logic             nonzero
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  function automatic logic [WIDTH-1:0] sat_down(input logic [WIDTH-1:0] cur,
                                                input logic [WIDTH-1:0] dec);
    if (cur >= dec) return cur - dec;
    else            return ZERO;
  endfunction

  logic [WIDTH-1:0] value_nxt;

  always_comb begin
    unique case (action)
      ACT_LOAD:  value_nxt = start_val;
      ACT_CLEAR: value_nxt = ZERO;
      ACT_STEP:  value_nxt = sat_down(value, step);
      default:   value_nxt = value;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value   <= ZERO;
      nonzero <= 1'b0;
    end else if (action != ACT_HOLD) begin
      value   <= value_nxt;
      nonzero <= (value_nxt != ZERO);
    end
  end

endmodule

// File: rtl/dtmr_timer.sv
module dtmr_timer
  import dtmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             load_req,
  input  logic [WIDTH-1:0] start_val,
  input  logic [WIDTH-1:0] step,
  output logic [WIDTH-1:0] count,
  output logic             busy
);

  logic         edge_load;
  logic         any_load;
  dtmr_action_e action;

  dtmr_edge_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .level (run),
    .rise  (edge_load)
  );

  assign any_load = edge_load | (tick & load_req);
  assign action   = pick_action(tick, any_load, run);

  dtmr_value_reg #(.WIDTH(WIDTH)) u_val (
    .clk       (clk),
    .rst       (rst),
    .action    (action),
    .start_val (start_val),
    .step      (step),
    .value     (count),
    .nonzero   (busy)
  );

endmodule

// File: rtl/dtmr_checks.sv
module dtmr_checks #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             load_req,
  input logic [WIDTH-1:0] start_val,
  input logic [WIDTH-1:0] step,
  input logic [WIDTH-1:0] count,
  input logic             busy,
  input logic             edge_load,
  input logic             any_load
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (count == '0) && !busy);

  a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count) && $stable(busy));

  a_r3_edge_on_strobe: assert property (@(posedge clk) disable iff (rst)
    edge_load |-> tick && run);

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    tick && load_req |=> count == $past(start_val));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    tick && !any_load && !run |=> count == '0);

  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    tick && !any_load && run && (count >= step)
      |=> count == WIDTH'($past(count) - $past(step)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (rst)
    tick && !any_load && run && (count < step) |=> count == '0);

  a_r8_busy: assert property (@(posedge clk) disable iff (rst)
    busy == (count != '0));

endmodule

bind dtmr_timer dtmr_checks #(.WIDTH(WIDTH)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .run       (run),
  .load_req  (load_req),
  .start_val (start_val),
  .step      (step),
  .count     (count),
  .busy      (busy),
  .edge_load (edge_load),
  .any_load  (any_load)
);

// File: tb/dtmr_timer_test.sv
module dtmr_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic             run = 1'b0;
  logic             load_req = 1'b0;
  logic [WIDTH-1:0] start_val = '0;
  logic [WIDTH-1:0] step = '0;
  logic [WIDTH-1:0] count;
  logic             busy;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmr_timer #(.WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .load_req(load_req),
    .start_val(start_val), .step(step), .count(count), .busy(busy)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (count !== exp || busy !== (exp != 0)) begin
      n_fail++;
      $display("FAIL %s: count=%0d busy=%0b expected count=%0d busy=%0b",
               req, count, busy, exp, (exp != 0));
    end
  endtask

  // One strobe with given run/load, then sample away from the edge.
  task automatic strobe(input logic r, input logic l,
                        input logic [WIDTH-1:0] exp, input string req);
    @(negedge clk);
    run = r; load_req = l; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0; load_req = 1'b0;
    check(req, exp);
  endtask

  task automatic test_reset();
    run = 1'b1; start_val = 16'd5; step = 16'd1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'd0);
    rst = 1'b0;
  endtask

  task automatic test_counter();
    strobe(1, 0, 16'd5, "R1 R3 load after reset");
    for (int k = 4; k >= 0; k--) strobe(1, 0, WIDTH'(k), "R6 count down");
    strobe(1, 0, 16'd0, "R7 stay at zero");
  endtask

  task automatic test_clear();
    strobe(0, 0, 16'd0, "R5 run low");
    strobe(1, 0, 16'd5, "R3 reload on edge");
    strobe(1, 0, 16'd4, "R6 step");
    strobe(0, 0, 16'd0, "R5 clear mid count");
  endtask

  task automatic test_timer();
    start_val = 16'd10; step = 16'd3;
    strobe(1, 0, 16'd10, "R3 timer load");
    strobe(1, 0, 16'd7,  "R6 timer step");
    strobe(1, 0, 16'd4,  "R6 timer step");
    strobe(1, 0, 16'd1,  "R6 timer step");
    strobe(1, 0, 16'd0,  "R7 below step saturates");
  endtask

  task automatic test_ext_load();
    start_val = 16'd9;
    strobe(0, 1, 16'd9, "R4 load with run low");
    strobe(0, 0, 16'd0, "R5 clear after load");
    strobe(1, 0, 16'd9, "R3 edge load");
    start_val = 16'd6;
    strobe(1, 1, 16'd6, "R4 load while running");
    strobe(1, 0, 16'd3, "R6 step after load");
  endtask

  task automatic test_hold();
    step = 16'd1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      run = (c == 1) ? 1'b0 : 1'b1;
      start_val = 16'd100;
      step = 16'd2;
      check("R2 hold off strobe", 16'd3);
    end
    step = 16'd1;
    strobe(1, 0, 16'd2, "R10 R9 no reload from glitch");
  endtask

  task automatic test_wide();
    start_val = 16'hFFFF; step = 16'h8000;
    strobe(0, 0, 16'd0, "R5 clear");
    strobe(1, 0, 16'hFFFF, "R3 max load");
    strobe(1, 0, 16'h7FFF, "R6 large step");
    strobe(1, 0, 16'd0, "R7 no wrap");
  endtask

  initial begin
    test_reset();
    test_counter();
    test_clear();
    test_timer();
    test_ext_load();
    test_hold();
    test_wide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: count=%0d expected completion", count);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule